// File: doc/BRIEF.md
# Shift-Capable 32-bit ALU

This block is the combinational arithmetic and logic unit of a multi-cycle processor core. Each cycle the sequencer presents two operands and a 4-bit operation code, and the unit returns a 32-bit result together with a flag that is high when that result is all zeros. The core reads the flag after a subtraction to decide an equality branch.

The unit covers bitwise OR, AND and XOR, wrapping addition and subtraction, signed and unsigned set-less-than, and logical left and right shifts. Shifts act on the second operand `opB`, by a distance taken from a dedicated 5-bit input rather than from either operand. Internally a decoder turns the code into a one-hot set of select strobes. A datapath shares one adder among addition, subtraction and both comparisons, and holds two barrel shifters.

Top module: `shiftAlu`

## Requirements
- R1: Code 4'b0000 returns `opA | opB`, code 4'b0110 returns `opA & opB`, and code 4'b0101 returns `opA ^ opB`.
- R2: Code 4'b0011 returns `opA + opB` and code 4'b0100 returns `opA - opB`. Both wrap modulo 2^32, and no overflow indication exists.
- R3: Code 4'b0010 returns 1 in bit 0 when `opA` is less than `opB` as two's-complement signed values, and 0 there otherwise.
- R4: Code 4'b0001 returns 1 in bit 0 when `opA` is less than `opB` as unsigned values, and 0 there otherwise.
- R5: For codes 4'b0010 and 4'b0001, result bits 31 to 1 are always zero.
- R6: Code 4'b1111 returns `opB` shifted left by `shamt` places, with zeros filling the vacated low bits. `opA` has no effect on the result.
- R7: Code 4'b1110 returns `opB` shifted right by `shamt` places, with zeros filling the vacated high bits. `opA` has no effect on the result.
- R8: Every other code (4'b0111 through 4'b1101) returns a result of zero.
- R9: `zero` is 1 exactly when all 32 bits of `result` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | 32 | First operand |
| opB | input | 32 | Second operand, and the value that is shifted |
| aluCtl | input | 4 | Operation code |
| shamt | input | 5 | Shift distance for the two shift codes |
| result | output | 32 | Operation result |
| zero | output | 1 | High when `result` is all zeros |

## Verification
The hardest cases to reach are the comparison outcomes that depend on signed overflow inside the shared subtractor. One example is the most negative value compared against a positive one: the raw sign of the difference gives the wrong answer there. Random operands almost never land on these cases. For that reason, every code and every shift distance is swept over the full cross product of a set of edge operands (0, 1, the largest positive value, the most negative value and all ones), as well as random pairs. The shift sweep covers all 32 distances with random `opA` values, which shows that `opA` never reaches a shift result.

// File: rtl/shiftAluPkg.sv
package shiftAluPkg;

  typedef enum logic [3:0] {
    OP_OR   = 4'b0000,
    OP_SLTU = 4'b0001,
    OP_SLT  = 4'b0010,
    OP_ADD  = 4'b0011,
    OP_SUB  = 4'b0100,
    OP_XOR  = 4'b0101,
    OP_AND  = 4'b0110,
    OP_SRL  = 4'b1110,
    OP_SLL  = 4'b1111
  } aluOp_e;

  // One strobe per datapath function; at most one is high.
  typedef struct packed {
    logic selOr;
    logic selAnd;
    logic selXor;
    logic selAdd;
    logic selSub;
    logic selSlt;
    logic selSltu;
    logic selSll;
    logic selSrl;
  } aluStrobes_t;

endpackage

// File: rtl/aluDecode.sv
module aluDecode
  import shiftAluPkg::*;
(
  input  logic [3:0]  aluCtl,
  output aluStrobes_t strb
);

  always_comb begin
    strb = '0;
    case (aluCtl)
      OP_OR:   strb.selOr   = 1'b1;
      OP_AND:  strb.selAnd  = 1'b1;
      OP_XOR:  strb.selXor  = 1'b1;
      OP_ADD:  strb.selAdd  = 1'b1;
      OP_SUB:  strb.selSub  = 1'b1;
      OP_SLT:  strb.selSlt  = 1'b1;
      OP_SLTU: strb.selSltu = 1'b1;
      OP_SLL:  strb.selSll  = 1'b1;
      OP_SRL:  strb.selSrl  = 1'b1;
      default: strb = '0;   // undefined codes select nothing (R8)
    endcase
  end

  // The result mux relies on never seeing two functions at once.
  always_comb begin
    p_single_strobe_r1: assert ($onehot0(strb))
      else $error("decoder raised more than one strobe for code %b", aluCtl);
  end

endmodule

// File: rtl/aluShifter.sv
module aluShifter #(
  parameter int WIDTH = 32,
  parameter bit LEFT  = 1'b1,
  localparam int SHW  = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] din,
  input  logic [SHW-1:0]   amt,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stage [0:SHW];

  assign stage[0] = din;

  // Log-depth barrel: stage k moves by 2**k when amt[k] is set.
  for (genvar k = 0; k < SHW; k++) begin : g_stage
    if (LEFT) begin : g_left
      assign stage[k+1] = amt[k] ? (stage[k] << (1 << k)) : stage[k];
    end else begin : g_right
      assign stage[k+1] = amt[k] ? (stage[k] >> (1 << k)) : stage[k];
    end
  end

  assign dout = stage[SHW];

endmodule

// File: rtl/aluDatapath.sv
module aluDatapath
  import shiftAluPkg::*;
#(
  parameter int WIDTH = 32,
  localparam int SHW  = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [SHW-1:0]   shamt,
  input  aluStrobes_t      strb,
  output logic [WIDTH-1:0] result
);

  logic             subLike;
  logic [WIDTH-1:0] bOperand;
  logic [WIDTH:0]   sumExt;
  logic [WIDTH-1:0] sumOut;
  logic             carryOut;
  logic             ovf;
  logic             ltSigned;
  logic             ltUnsigned;
  logic [WIDTH-1:0] shlOut;
  logic [WIDTH-1:0] shrOut;

  // One adder serves add, subtract and both comparisons.
  assign subLike  = strb.selSub | strb.selSlt | strb.selSltu;
  assign bOperand = subLike ? ~opB : opB;
  assign sumExt   = {1'b0, opA} + {1'b0, bOperand} + (WIDTH+1)'(subLike);
  assign sumOut   = sumExt[WIDTH-1:0];
  assign carryOut = sumExt[WIDTH];

  assign ovf        = (opA[WIDTH-1] ^ opB[WIDTH-1]) & (opA[WIDTH-1] ^ sumOut[WIDTH-1]);
  assign ltSigned   = sumOut[WIDTH-1] ^ ovf;
  assign ltUnsigned = ~carryOut;

  aluShifter #(.WIDTH(WIDTH), .LEFT(1'b1)) u_shl (
    .din (opB),
    .amt (shamt),
    .dout(shlOut)
  );

  aluShifter #(.WIDTH(WIDTH), .LEFT(1'b0)) u_shr (
    .din (opB),
    .amt (shamt),
    .dout(shrOut)
  );

  // AND-OR select: no strobe gives zero.
  always_comb begin
    result = '0;
    result |= {WIDTH{strb.selOr}}  & (opA | opB);
    result |= {WIDTH{strb.selAnd}} & (opA & opB);
    result |= {WIDTH{strb.selXor}} & (opA ^ opB);
    result |= {WIDTH{strb.selAdd | strb.selSub}} & sumOut;
    result |= {WIDTH{strb.selSlt}}  & {{(WIDTH-1){1'b0}}, ltSigned};
    result |= {WIDTH{strb.selSltu}} & {{(WIDTH-1){1'b0}}, ltUnsigned};
    result |= {WIDTH{strb.selSll}} & shlOut;
    result |= {WIDTH{strb.selSrl}} & shrOut;
  end

  always_comb begin
    p_cmp_upper_clear_r5: assert (!(strb.selSlt || strb.selSltu) || result[WIDTH-1:1] == '0)
      else $error("comparison result has upper bits set: %h", result);
    p_undefined_clear_r8: assert ((strb != '0) || result == '0)
      else $error("no function selected but result is %h", result);
    p_shift_zero_dist_r6: assert (!((strb.selSll || strb.selSrl) && shamt == '0) || result == opB)
      else $error("zero-distance shift changed operand: %h vs %h", result, opB);
    p_sub_equal_r2: assert (!(strb.selSub && opA == opB) || result == '0)
      else $error("equal operands subtract to %h", result);
    p_signed_order_r3: assert (!(strb.selSlt && opA[WIDTH-1] != opB[WIDTH-1]) || result[0] == opA[WIDTH-1])
      else $error("signed compare wrong across sign boundary");
  end

endmodule

// File: rtl/shiftAlu.sv
module shiftAlu
  import shiftAluPkg::*;
#(
  parameter int WIDTH = 32,
  localparam int SHW  = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [3:0]       aluCtl,
  input  logic [SHW-1:0]   shamt,
  output logic [WIDTH-1:0] result,
  output logic             zero
);

  aluStrobes_t strb;

  aluDecode u_decode (
    .aluCtl(aluCtl),
    .strb  (strb)
  );

  aluDatapath #(.WIDTH(WIDTH)) u_datapath (
    .opA   (opA),
    .opB   (opB),
    .shamt (shamt),
    .strb  (strb),
    .result(result)
  );

  assign zero = (result == '0);

  always_comb begin
    p_sub_equal_flag_r9: assert (!(aluCtl == OP_SUB && opA == opB) || zero)
      else $error("equal operands under subtract did not raise zero flag");
  end

endmodule

// File: tb/test_shiftAlu.sv
module test_shiftAlu;

  logic        clk = 1'b0;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic [3:0]  aluCtl = 4'b0000;
  logic [4:0]  shamt = '0;
  logic [31:0] result;
  logic        zero;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  shiftAlu i_shiftAlu (
    .opA   (opA),
    .opB   (opB),
    .aluCtl(aluCtl),
    .shamt (shamt),
    .result(result),
    .zero  (zero)
  );

  function automatic logic [31:0] edgeVal(input int i);
    case (i)
      0: edgeVal = 32'h0000_0000;
      1: edgeVal = 32'h0000_0001;
      2: edgeVal = 32'h7FFF_FFFF;
      3: edgeVal = 32'h8000_0000;
      default: edgeVal = 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic string reqTag(input logic [3:0] op);
    case (op)
      4'b0000, 4'b0101, 4'b0110: reqTag = "R1";
      4'b0011, 4'b0100:          reqTag = "R2";
      4'b0010:                   reqTag = "R3/R5";
      4'b0001:                   reqTag = "R4/R5";
      4'b1111:                   reqTag = "R6";
      4'b1110:                   reqTag = "R7";
      default:                   reqTag = "R8";
    endcase
  endfunction

  // Reference built arithmetically from the requirements.
  function automatic logic [31:0] model(input logic [3:0] op, input logic [31:0] a,
                                        input logic [31:0] b, input logic [4:0] sh);
    logic [63:0] pow2;
    logic [63:0] wide;
    logic        signedLess;
    pow2 = 64'd1 << sh;
    if (a[31] != b[31]) signedLess = a[31];
    else                signedLess = (a < b);
    case (op)
      4'b0000: model = a | b;
      4'b0110: model = a & b;
      4'b0101: model = a ^ b;
      4'b0011: begin wide = {32'd0, a} + {32'd0, b}; model = wide[31:0]; end
      4'b0100: begin wide = {32'd0, a} + (64'h1_0000_0000 - {32'd0, b}); model = wide[31:0]; end
      4'b0010: model = {31'd0, signedLess};
      4'b0001: model = {31'd0, (a < b)};
      4'b1111: begin wide = {32'd0, b} * pow2; model = wide[31:0]; end
      4'b1110: begin wide = {32'd0, b} / pow2; model = wide[31:0]; end
      default: model = 32'd0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: code=%b a=%h b=%h sh=%0d actual=%h expected=%h",
               tag, aluCtl, opA, opB, shamt, act, exp);
    end
  endtask

  task automatic apply(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic [4:0] sh);
    logic [31:0] exp;
    @(negedge clk);
    aluCtl = op; opA = a; opB = b; shamt = sh;
    #1;
    exp = model(op, a, b, sh);
    check(reqTag(op), result, exp);
    check("R9", {31'd0, zero}, {31'd0, (exp == 32'd0)});
  endtask

  initial begin
    // Idle state: all-zero inputs select OR of zeros.
    #1;
    check("R1", result, 32'd0);
    check("R9", {31'd0, zero}, 32'd1);

    for (int op = 0; op < 16; op++) begin
      for (int sh = 0; sh < 32; sh++) begin
        for (int v = 0; v < 40; v++) begin
          logic [31:0] a;
          logic [31:0] b;
          if (v < 25) begin
            a = edgeVal(v / 5);
            b = edgeVal(v % 5);
          end else begin
            a = $urandom();
            b = $urandom();
            if (v == 39) b = a;   // equal operands for R9 after subtract
          end
          apply(op[3:0], a, b, sh[4:0]);
        end
      end
    end

    // Directed: A must not leak into shifts (R6, R7).
    apply(4'b1111, 32'hFFFF_FFFF, 32'h0000_0001, 5'd31);
    apply(4'b1110, 32'hFFFF_FFFF, 32'h8000_0000, 5'd31);
    // Signed overflow corner for R3.
    apply(4'b0010, 32'h8000_0000, 32'h0000_0001, 5'd0);
    apply(4'b0010, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 5'd0);

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

endmodule